// File: doc/BRIEF.md
# Programmable Interval Counter Bank

This block holds a small bank of identical 16-bit down counters behind an 8-bit register interface. Each counter has its own counting clock, a gate input and an output pin. Software programs a counter in two steps. It first writes a control byte to the shared control address. This byte picks the counter, the byte order for loading and reading, the operating behaviour and binary or four-digit decimal counting. Software then writes the preset value to that counter's own address.

Each counting clock and gate runs asynchronously to the system clock and is synchronised inside the block. A counter moves on each falling edge of its counting clock. Three behaviours are provided:

- **Terminal count:** the output stays low until the count expires.
- **Gate-triggered single pulse:** a rising edge on the gate starts, or restarts, a low pulse of programmed length.
- **Periodic divider:** the output dips low for one counting-clock period at the end of every cycle.

A counter can be read at any time without disturbing it. A snapshot command can also freeze a copy of the count for a consistent two-byte read.

Top module: `pit_timer`

## Requirements
- R1: After reset every counter output is high and a read of any counter address returns 0x00.
- R2: A write to address 3 is a control byte. Bits 7:6 select the counter, and the value 3 in these bits makes the write ignored. Bits 5:4 select the access: 00 snapshot, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 3:1 select the behaviour: 001 single pulse, 010 or 110 periodic divider, any other value terminal count. Bit 0 selects decimal counting. A read of address 3 returns 0x00.
- R3: With low-only access a byte write presets {0x00, byte}. With high-only access it presets {byte, 0x00}. With low-then-high access the first write is held and the preset changes only on the second write.
- R4: Reads follow the access byte order (low-then-high alternates, starting at the low byte after a control write) and never alter the count.
- R5: A snapshot command copies the count. The copy is returned by reads until it has been fully read, and further snapshot commands are ignored while it is held.
- R6: A counter changes at most once per falling edge of its counting clock, however long the clock stays low, and binary counting wraps from 0x0000 to 0xFFFF.
- R7: In decimal mode each 4-bit digit counts 9..0 with borrow: 0100 becomes 0099 and 0000 becomes 9999.
- R8: Terminal count: the output goes low on the control write and on each completed preset. The next counting edge loads the preset. The output goes high when a decrement reaches zero and stays high.
- R9: Terminal count: while the gate is low the count holds, and counting resumes when the gate returns high.
- R10: Single pulse: after a preset, a gate rising edge makes the next counting edge load the preset and drive the output low. The output returns high when the count reaches zero. A new gate rising edge reloads the count mid-pulse.
- R11: Periodic divider: the output goes low when the count reaches 1. The next counting edge reloads the preset and returns the output high, so the period equals the preset.
- R12: Periodic divider: gate low forces the output high and holds the count. A gate rising edge reloads the preset on the next counting edge.
- R13: Periodic divider: a preset written while the counter runs does not disturb the current cycle and is used at the next reload.
- R14: Counters are independent; activity on one never changes another's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus select |
| wr_en | input | 1 | Write strobe, one system cycle |
| rd_en | input | 1 | Read strobe, one system cycle, advances byte order |
| addr | input | 2 | 0..2 counter, 3 control byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed counter, combinational |
| ctr_clk | input | NUM_CTR | Counting clocks, asynchronous |
| ctr_gate | input | NUM_CTR | Gate inputs, asynchronous |
| ctr_out | output | NUM_CTR | Counter outputs |

## Verification
The hardest situations to reach are those in the periodic divider and single-pulse behaviours where a gate edge or a new preset arrives partway through a cycle. These include the gate dropping while the output is in its one-period low dip, a preset rewritten during the dip, and a retrigger halfway through a pulse. The stimulus reaches them by issuing an exact number of full counting-clock pulses, each stretched over several system cycles so that it passes the synchroniser. The stimulus then changes the gate or writes the preset at a known count and samples the output and a two-byte read.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CNT_W   = 16;
    localparam int BCD_DIG = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_BOTH = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        MD_TERM    = 2'd0,
        MD_ONESHOT = 2'd1,
        MD_RATE    = 2'd2
    } mode_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_t;

    function automatic mode_e mode_of(input logic [2:0] f);
        if (f == 3'b001)
            return MD_ONESHOT;
        else if (f[1:0] == 2'b10)
            return MD_RATE;
        else
            return MD_TERM;
    endfunction

    function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        for (int i = 0; i < BCD_DIG; i++) begin
            if (borrow) begin
                if (v[4*i +: 4] == 4'd0) begin
                    r[4*i +: 4] = 4'd9;
                end else begin
                    r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic digits_ok(input logic [CNT_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < BCD_DIG; i++)
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
        return bcd ? bcd_dec(v) : v - CNT_W'(1);
    endfunction

endpackage

// File: rtl/pit_in_sync.sv
module pit_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_clk,
    input  logic raw_gate,
    output logic tick,
    output logic gate_lvl,
    output logic gate_rise
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] gt;
        logic              ck_prev;
        logic              gt_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.ck      = {sync_q.ck[STAGES-2:0], raw_clk};
        sync_d.gt      = {sync_q.gt[STAGES-2:0], raw_gate};
        sync_d.ck_prev = sync_q.ck[TOP];
        sync_d.gt_prev = sync_q.gt[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.ck      <= '1;
            sync_q.gt      <= '0;
            sync_q.ck_prev <= 1'b1;
            sync_q.gt_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign tick      = sync_q.ck_prev & ~sync_q.ck[TOP];
    assign gate_lvl  = sync_q.gt[TOP];
    assign gate_rise = sync_q.gt[TOP] & ~sync_q.gt_prev;

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       gate_lvl,
    input  logic       gate_rise,
    input  logic       cfg_we,
    input  acc_e       cfg_acc,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_bcd,
    input  logic       snap_we,
    input  logic       data_we,
    input  logic [7:0] wdata,
    input  logic       rd_re,
    output logic [7:0] rdata,
    output logic       out
);
    typedef struct packed {
        mode_e            mode;
        logic             bcd;
        acc_e             acc;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] preset;
        logic [7:0]       lo_buf;
        logic             wr_hi;
        logic             rd_hi;
        logic             snap_v;
        logic [CNT_W-1:0] snap;
        logic             pend;
        logic             run;
        logic             have;
        logic             trig;
        logic             outp;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic             done;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] src;
    mode_e            new_mode;

    always_comb begin
        ctr_d    = ctr_q;
        done     = 1'b0;
        nxt      = cnt_dec(ctr_q.cnt, ctr_q.bcd);
        new_mode = mode_of(cfg_mode);

        // counting edge
        if (tick) begin
            case (ctr_q.mode)
                MD_ONESHOT: begin
                    if (ctr_q.trig) begin
                        ctr_d.cnt  = ctr_q.preset;
                        ctr_d.outp = 1'b0;
                        ctr_d.trig = 1'b0;
                        ctr_d.run  = 1'b1;
                    end else if (ctr_q.run) begin
                        ctr_d.cnt = nxt;
                        if (nxt == '0) ctr_d.outp = 1'b1;
                    end
                end
                MD_RATE: begin
                    if (ctr_q.pend) begin
                        ctr_d.cnt  = ctr_q.preset;
                        ctr_d.pend = 1'b0;
                        ctr_d.run  = 1'b1;
                        ctr_d.outp = 1'b1;
                    end else if (ctr_q.run && gate_lvl) begin
                        if (ctr_q.cnt == CNT_W'(1)) begin
                            ctr_d.cnt  = ctr_q.preset;
                            ctr_d.outp = 1'b1;
                        end else begin
                            ctr_d.cnt = nxt;
                            if (nxt == CNT_W'(1)) ctr_d.outp = 1'b0;
                        end
                    end
                end
                default: begin
                    if (ctr_q.pend) begin
                        ctr_d.cnt  = ctr_q.preset;
                        ctr_d.pend = 1'b0;
                        ctr_d.run  = 1'b1;
                    end else if (ctr_q.run && gate_lvl) begin
                        ctr_d.cnt = nxt;
                        if (nxt == '0) ctr_d.outp = 1'b1;
                    end
                end
            endcase
        end

        // gate effects
        if (ctr_q.mode == MD_RATE) begin
            if (!gate_lvl) ctr_d.outp = 1'b1;
            if (gate_rise && ctr_q.run) ctr_d.pend = 1'b1;
        end
        if (ctr_q.mode == MD_ONESHOT && gate_rise && ctr_q.have)
            ctr_d.trig = 1'b1;

        // bus side
        if (cfg_we) begin
            ctr_d.mode   = new_mode;
            ctr_d.bcd    = cfg_bcd;
            ctr_d.acc    = cfg_acc;
            ctr_d.wr_hi  = 1'b0;
            ctr_d.rd_hi  = 1'b0;
            ctr_d.snap_v = 1'b0;
            ctr_d.pend   = 1'b0;
            ctr_d.run    = 1'b0;
            ctr_d.have   = 1'b0;
            ctr_d.trig   = 1'b0;
            ctr_d.outp   = (new_mode != MD_TERM);
        end else if (snap_we) begin
            if (!ctr_q.snap_v) begin
                ctr_d.snap   = ctr_q.cnt;
                ctr_d.snap_v = 1'b1;
            end
        end else if (data_we) begin
            case (ctr_q.acc)
                ACC_LO: begin
                    ctr_d.preset = {8'h00, wdata};
                    done         = 1'b1;
                end
                ACC_HI: begin
                    ctr_d.preset = {wdata, 8'h00};
                    done         = 1'b1;
                end
                default: begin
                    if (!ctr_q.wr_hi) begin
                        ctr_d.lo_buf = wdata;
                        ctr_d.wr_hi  = 1'b1;
                    end else begin
                        ctr_d.preset = {wdata, ctr_q.lo_buf};
                        ctr_d.wr_hi  = 1'b0;
                        done         = 1'b1;
                    end
                end
            endcase
            if (done) begin
                ctr_d.have = 1'b1;
                case (ctr_q.mode)
                    MD_TERM: begin
                        ctr_d.pend = 1'b1;
                        ctr_d.run  = 1'b0;
                        ctr_d.outp = 1'b0;
                    end
                    MD_RATE: begin
                        if (!ctr_q.run) ctr_d.pend = 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (rd_re) begin
            if (ctr_q.acc == ACC_LO || ctr_q.acc == ACC_HI) begin
                ctr_d.snap_v = 1'b0;
            end else begin
                ctr_d.rd_hi = ~ctr_q.rd_hi;
                if (ctr_q.rd_hi) ctr_d.snap_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q        <= '0;
            ctr_q.mode   <= MD_TERM;
            ctr_q.acc    <= ACC_BOTH;
            ctr_q.outp   <= 1'b1;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    always_comb begin
        src = ctr_q.snap_v ? ctr_q.snap : ctr_q.cnt;
        case (ctr_q.acc)
            ACC_LO:  rdata = src[7:0];
            ACC_HI:  rdata = src[15:8];
            default: rdata = ctr_q.rd_hi ? src[15:8] : src[7:0];
        endcase
    end

    assign out = ctr_q.outp;

    // R4
    read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_re && !tick) |=> $stable(ctr_q.cnt));

    // R8
    term_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.mode == MD_TERM && $fell(ctr_q.outp)) |-> $past(cfg_we || data_we));

    // R11
    rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.mode == MD_RATE && !ctr_q.outp) |-> (ctr_q.cnt == CNT_W'(1)));

    // R7
    bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.bcd && $past(ctr_q.bcd) && digits_ok($past(ctr_q.cnt))
         && digits_ok($past(ctr_q.preset))) |-> digits_ok(ctr_q.cnt));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CTR     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [NUM_CTR-1:0] ctr_clk,
    input  logic [NUM_CTR-1:0] ctr_gate,
    output logic [NUM_CTR-1:0] ctr_out
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    ctrl_t      cw;
    logic       bus_wr;
    logic       bus_rd;
    logic       cw_wr;
    logic [7:0] rd_byte [NUM_CTR];

    assign cw     = ctrl_t'(wdata);
    assign bus_wr = cs & wr_en;
    assign bus_rd = cs & rd_en;
    assign cw_wr  = bus_wr & (addr == CTRL_ADDR);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic tick, gate_lvl, gate_rise;
        logic hit, cfg_we, snap_we, data_we, rd_re;

        assign hit     = cw_wr & (cw.sel == 2'(i));
        assign cfg_we  = hit & (cw.acc != ACC_SNAP);
        assign snap_we = hit & (cw.acc == ACC_SNAP);
        assign data_we = bus_wr & (addr == 2'(i));
        assign rd_re   = bus_rd & (addr == 2'(i));

        pit_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_clk   (ctr_clk[i]),
            .raw_gate  (ctr_gate[i]),
            .tick      (tick),
            .gate_lvl  (gate_lvl),
            .gate_rise (gate_rise)
        );

        pit_counter u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .gate_lvl  (gate_lvl),
            .gate_rise (gate_rise),
            .cfg_we    (cfg_we),
            .cfg_acc   (cw.acc),
            .cfg_mode  (cw.mode),
            .cfg_bcd   (cw.bcd),
            .snap_we   (snap_we),
            .data_we   (data_we),
            .wdata     (wdata),
            .rd_re     (rd_re),
            .rdata     (rd_byte[i]),
            .out       (ctr_out[i])
        );
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_CTR; i++)
            if (addr == 2'(i)) rdata = rd_byte[i];
    end

    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctr_out == '1));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && addr == CTRL_ADDR) |-> (rdata == 8'h00));

endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [N-1:0] cclk = '1;
    logic [N-1:0] gate = '1;
    logic [N-1:0] cout;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pit_timer #(.NUM_CTR(N)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ctr_clk(cclk), .ctr_gate(gate), .ctr_out(cout)
    );

    localparam logic [2:0] OW = 3'd0, ORD = 3'd1, OT = 3'd2, OG = 3'd3, OO = 3'd4;
    localparam int NV = 121;
    // {op, target, data, expected, requirement}
    localparam logic [24:0] VEC [NV] = '{
        {OW, 2'd3, 8'h30, 8'h00, 4'd2},   //   1 ctr0 terminal count, R2
        {OO, 2'd0, 8'h00, 8'h00, 4'd8},   //     R8 low on control
        {OW, 2'd0, 8'h05, 8'h00, 4'd3},
        {OW, 2'd0, 8'h00, 8'h00, 4'd3},
        {OO, 2'd0, 8'h00, 8'h00, 4'd8},
        {OT, 2'd0, 8'd1,  8'h00, 4'd8},
        {ORD,2'd0, 8'h00, 8'h05, 4'd3},   //     R3 two-byte preset
        {ORD,2'd0, 8'h00, 8'h00, 4'd4},
        {OT, 2'd0, 8'd4,  8'h00, 4'd6},
        {OO, 2'd0, 8'h00, 8'h00, 4'd8},   //  10
        {OT, 2'd0, 8'd1,  8'h00, 4'd8},
        {OO, 2'd0, 8'h00, 8'h01, 4'd8},   //     R8 high at zero
        {OT, 2'd0, 8'd1,  8'h00, 4'd6},
        {OO, 2'd0, 8'h00, 8'h01, 4'd8},
        {ORD,2'd0, 8'h00, 8'hFF, 4'd6},   //     R6 wrap
        {ORD,2'd0, 8'h00, 8'hFF, 4'd6},
        {OW, 2'd3, 8'h30, 8'h00, 4'd9},   //     R9 gate hold
        {OW, 2'd0, 8'h03, 8'h00, 4'd9},
        {OW, 2'd0, 8'h00, 8'h00, 4'd9},
        {OT, 2'd0, 8'd1,  8'h00, 4'd9},   //  20
        {OG, 2'd0, 8'h00, 8'h00, 4'd9},
        {OT, 2'd0, 8'd2,  8'h00, 4'd9},
        {ORD,2'd0, 8'h00, 8'h03, 4'd9},
        {ORD,2'd0, 8'h00, 8'h00, 4'd9},
        {OG, 2'd0, 8'h01, 8'h00, 4'd9},
        {OT, 2'd0, 8'd2,  8'h00, 4'd9},
        {ORD,2'd0, 8'h00, 8'h01, 4'd9},
        {ORD,2'd0, 8'h00, 8'h00, 4'd9},
        {OO, 2'd0, 8'h00, 8'h00, 4'd8},
        {OT, 2'd0, 8'd1,  8'h00, 4'd8},   //  30
        {OO, 2'd0, 8'h00, 8'h01, 4'd8},
        {OW, 2'd3, 8'h70, 8'h00, 4'd5},   //     R5 snapshot on ctr1
        {OW, 2'd1, 8'h34, 8'h00, 4'd5},
        {OW, 2'd1, 8'h12, 8'h00, 4'd5},
        {OT, 2'd1, 8'd1,  8'h00, 4'd5},
        {OW, 2'd3, 8'h40, 8'h00, 4'd5},
        {OT, 2'd1, 8'd2,  8'h00, 4'd5},
        {OW, 2'd3, 8'h40, 8'h00, 4'd5},
        {ORD,2'd1, 8'h00, 8'h34, 4'd5},
        {ORD,2'd1, 8'h00, 8'h12, 4'd5},   //  40
        {ORD,2'd1, 8'h00, 8'h32, 4'd5},
        {ORD,2'd1, 8'h00, 8'h12, 4'd5},
        {OW, 2'd3, 8'hB1, 8'h00, 4'd7},   //     R7 decimal on ctr2
        {OW, 2'd2, 8'h01, 8'h00, 4'd7},
        {OW, 2'd2, 8'h01, 8'h00, 4'd7},
        {OT, 2'd2, 8'd1,  8'h00, 4'd7},
        {OT, 2'd2, 8'd2,  8'h00, 4'd7},
        {ORD,2'd2, 8'h00, 8'h99, 4'd7},
        {ORD,2'd2, 8'h00, 8'h00, 4'd7},
        {OW, 2'd3, 8'h90, 8'h00, 4'd3},   //  50 R3 low-only
        {OW, 2'd2, 8'h07, 8'h00, 4'd3},
        {OT, 2'd2, 8'd1,  8'h00, 4'd3},
        {ORD,2'd2, 8'h00, 8'h07, 4'd3},
        {ORD,2'd2, 8'h00, 8'h07, 4'd4},
        {OW, 2'd3, 8'hA0, 8'h00, 4'd3},   //     R3 high-only
        {OW, 2'd2, 8'h02, 8'h00, 4'd3},
        {OT, 2'd2, 8'd1,  8'h00, 4'd3},
        {ORD,2'd2, 8'h00, 8'h02, 4'd3},
        {OT, 2'd2, 8'd1,  8'h00, 4'd6},
        {ORD,2'd2, 8'h00, 8'h01, 4'd6},   //  60
        {OW, 2'd3, 8'hF0, 8'h00, 4'd2},   //     R2 select 3 ignored
        {ORD,2'd2, 8'h00, 8'h01, 4'd2},
        {ORD,2'd3, 8'h00, 8'h00, 4'd2},
        {OW, 2'd3, 8'h34, 8'h00, 4'd11},  //     R11 divider on ctr0
        {OO, 2'd0, 8'h00, 8'h01, 4'd11},
        {OW, 2'd0, 8'h03, 8'h00, 4'd11},
        {OW, 2'd0, 8'h00, 8'h00, 4'd11},
        {OT, 2'd0, 8'd1,  8'h00, 4'd11},
        {OO, 2'd0, 8'h00, 8'h01, 4'd11},
        {OT, 2'd0, 8'd1,  8'h00, 4'd11},  //  70
        {OO, 2'd0, 8'h00, 8'h01, 4'd11},
        {OT, 2'd0, 8'd1,  8'h00, 4'd11},
        {OO, 2'd0, 8'h00, 8'h00, 4'd11},
        {OT, 2'd0, 8'd1,  8'h00, 4'd11},
        {OO, 2'd0, 8'h00, 8'h01, 4'd11},
        {OT, 2'd0, 8'd2,  8'h00, 4'd11},
        {OO, 2'd0, 8'h00, 8'h00, 4'd11},
        {OW, 2'd0, 8'h05, 8'h00, 4'd13},  //     R13 preset while running
        {OW, 2'd0, 8'h00, 8'h00, 4'd13},
        {OO, 2'd0, 8'h00, 8'h00, 4'd13},  //  80
        {OT, 2'd0, 8'd1,  8'h00, 4'd13},
        {OO, 2'd0, 8'h00, 8'h01, 4'd13},
        {ORD,2'd0, 8'h00, 8'h05, 4'd13},
        {ORD,2'd0, 8'h00, 8'h00, 4'd13},
        {OT, 2'd0, 8'd4,  8'h00, 4'd11},
        {OO, 2'd0, 8'h00, 8'h00, 4'd11},
        {OG, 2'd0, 8'h00, 8'h00, 4'd12},  //     R12 gate low in the dip
        {OO, 2'd0, 8'h00, 8'h01, 4'd12},
        {OT, 2'd0, 8'd2,  8'h00, 4'd12},
        {ORD,2'd0, 8'h00, 8'h01, 4'd12},  //  90
        {ORD,2'd0, 8'h00, 8'h00, 4'd12},
        {OG, 2'd0, 8'h01, 8'h00, 4'd12},
        {OT, 2'd0, 8'd1,  8'h00, 4'd12},
        {ORD,2'd0, 8'h00, 8'h05, 4'd12},
        {ORD,2'd0, 8'h00, 8'h00, 4'd12},
        {ORD,2'd2, 8'h00, 8'h01, 4'd14},  //     R14 ctr2 untouched
        {OW, 2'd3, 8'h72, 8'h00, 4'd10},  //     R10 single pulse on ctr1
        {OO, 2'd1, 8'h00, 8'h01, 4'd10},
        {OW, 2'd1, 8'h03, 8'h00, 4'd10},
        {OW, 2'd1, 8'h00, 8'h00, 4'd10},  // 100
        {OT, 2'd1, 8'd2,  8'h00, 4'd10},
        {OO, 2'd1, 8'h00, 8'h01, 4'd10},
        {OG, 2'd1, 8'h00, 8'h00, 4'd10},
        {OG, 2'd1, 8'h01, 8'h00, 4'd10},
        {OO, 2'd1, 8'h00, 8'h01, 4'd10},
        {OT, 2'd1, 8'd1,  8'h00, 4'd10},
        {OO, 2'd1, 8'h00, 8'h00, 4'd10},
        {ORD,2'd1, 8'h00, 8'h03, 4'd10},
        {ORD,2'd1, 8'h00, 8'h00, 4'd10},
        {OT, 2'd1, 8'd2,  8'h00, 4'd10},  // 110
        {OO, 2'd1, 8'h00, 8'h00, 4'd10},
        {OG, 2'd1, 8'h00, 8'h00, 4'd10},
        {OG, 2'd1, 8'h01, 8'h00, 4'd10},
        {OT, 2'd1, 8'd1,  8'h00, 4'd10},
        {ORD,2'd1, 8'h00, 8'h03, 4'd10},
        {ORD,2'd1, 8'h00, 8'h00, 4'd10},
        {OT, 2'd1, 8'd2,  8'h00, 4'd10},
        {OO, 2'd1, 8'h00, 8'h00, 4'd10},
        {OT, 2'd1, 8'd1,  8'h00, 4'd10},
        {OO, 2'd1, 8'h00, 8'h01, 4'd10},  // 120
        {ORD,2'd2, 8'h00, 8'h01, 4'd14}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cs = 1'b1; addr = a; rd_en = 1'b1;
        #1;
        check(req, rdata, exp);
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic ctick(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cclk[idx] = 1'b0;
            repeat (4) @(negedge clk);
            cclk[idx] = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic set_gate(input int idx, input logic v);
        @(negedge clk); gate[idx] = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 out", {5'd0, cout}, 8'h07);
        for (int i = 0; i < N; i++) bus_rd(2'(i), 8'h00, "R1 read");

        for (int k = 0; k < NV; k++) begin
            logic [24:0] v;
            string tag;
            v   = VEC[k];
            tag = $sformatf("R%0d vec%0d", v[3:0], k);
            case (v[24:22])
                OW:  bus_wr(v[21:20], v[19:12]);
                ORD: bus_rd(v[21:20], v[11:4], tag);
                OT:  ctick(int'(v[21:20]), int'(v[19:12]));
                OG:  set_gate(int'(v[21:20]), v[12]);
                default: begin
                    @(negedge clk);
                    check(tag, {7'd0, cout[v[21:20]]}, v[11:4]);
                end
            endcase
        end

        // R3 first byte alone does not preset
        bus_wr(2'd3, 8'hB0);
        bus_wr(2'd2, 8'h10);
        ctick(2, 1);
        bus_rd(2'd2, 8'hFF, "R3 partial lo");
        bus_rd(2'd2, 8'h01, "R3 partial hi");
        bus_wr(2'd2, 8'h00);
        ctick(2, 1);
        bus_rd(2'd2, 8'h10, "R3 complete lo");
        bus_rd(2'd2, 8'h00, "R3 complete hi");

        // R6 long low phase counts once
        @(negedge clk); cclk[2] = 1'b0;
        repeat (20) @(negedge clk);
        cclk[2] = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(2'd2, 8'h0F, "R6 long low lo");
        bus_rd(2'd2, 8'h00, "R6 long low hi");

        // R7 decimal wrap from zero
        bus_wr(2'd3, 8'hB1);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd2, 8'h00);
        ctick(2, 2);
        bus_rd(2'd2, 8'h99, "R7 wrap lo");
        bus_rd(2'd2, 8'h99, "R7 wrap hi");

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 out after reset", {5'd0, cout}, 8'h07);
        bus_rd(2'd2, 8'h00, "R1 count after reset");

        finish_run();
    end

endmodule